// File: doc/BRIEF.md
# Resumable SHA-256 Compression Engine

This block computes the SHA-256 compression function over one 512-bit, already padded message block per command. It keeps the 256-bit chaining value in eight 32-bit hash registers. A start-fresh command loads the standard initial hash value and then compresses the block. A continue command compresses the block on top of whatever the hash registers already hold. Each command takes 64 rounds, one per clock, followed by a final feed-forward addition.

An outside agent can suspend a long message and resume it later. While the engine is idle, it writes a saved intermediate digest back into the hash registers one 32-bit word at a time, through a shared data input and a per-word enable. It then issues a continue command. The digest output always shows the current hash registers. The digest is read once the ready flag has returned high.

Top module: `sha256_resume_core`

## Requirements
- R1: After the active-low asynchronous reset, `ready_o` is 1, `digest_valid_o` is 0 and `digest_o` is all zeros.
- R2: A start-fresh command (`init_i`=1 while ready) on the padded single block for "abc" yields digest BA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD.
- R3: A continue command (`next_i`=1 while ready) chains on the current hash registers. For the standard 448-bit two-block message, start-fresh on block 1 gives 85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A, and continue on block 2 then gives 248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1.
- R4: While idle with no command, `wr_en_i[i]`=1 loads `wr_data_i` into hash word i on the clock edge. Word i appears at `digest_o[255-32*i : 224-32*i]`, so word 0 is the most significant.
- R5: After the intermediate digest 85E655D6…0E533A is restored through the write port, a continue command on the final block (all zero except 0x1C0 in bits 31:0) yields 248D6A61…19DB06C1.
- R6: `ready_o` drops on the edge that accepts a command. It returns high exactly 65 cycles later, together with `digest_valid_o`. `digest_valid_o` is never high while `ready_o` is low.
- R7: Any accepted state-restore write clears `digest_valid_o`.
- R8: Commands and writes presented while the engine is busy are ignored. The running computation and its result are unaffected.
- R9: If `init_i` and `next_i` are both high in the same accepting cycle, the start-fresh command wins. Writes presented in a command cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Start a new message from the initial hash value |
| next_i | input | 1 | Continue from the current hash registers |
| block_i | input | 512 | Padded message block, word 0 in bits 511:480 |
| wr_data_i | input | 32 | Data for hash-word restore |
| wr_en_i | input | 8 | Per-word restore enables, bit i selects word i |
| ready_o | output | 1 | Idle and able to accept a command |
| digest_o | output | 256 | Hash registers, word 0 most significant |
| digest_valid_o | output | 1 | Digest holds a completed compression result |

## Verification
The bench uses the published digests as golden values. Any error in the round function, the schedule or the feed-forward shows up as a wrong digest, not as a subtle timing slip. The restore test is aimed at word ordering: a design that reversed the word index would put the restored words in the wrong order and produce a wrong final digest, even though each single write looks plausible. Busy-time commands and writes target engines that let the hash registers or the round counter be disturbed mid-block, which would corrupt the "abc" result. The test with both commands high catches a priority inversion, which would chain on junk state instead of the initial value.

// File: rtl/sha256_pkg.sv
package sha256_pkg;
  localparam int WORD_W   = 32;
  localparam int HWORDS   = 8;
  localparam int BWORDS   = 16;
  localparam int ROUNDS   = 64;
  localparam int RND_W    = $clog2(ROUNDS);
  localparam int DIGEST_W = WORD_W * HWORDS;
  localparam int BLOCK_W  = WORD_W * BWORDS;

  typedef logic [WORD_W-1:0]            word_t;
  typedef logic [0:HWORDS-1][WORD_W-1:0] hstate_t;
  typedef logic [0:BWORDS-1][WORD_W-1:0] blk_t;

  localparam logic [DIGEST_W-1:0] SHA_IV =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

  localparam word_t SHA_K [0:ROUNDS-1] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sha256_sched.sv
module sha256_sched
  import sha256_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic [BLOCK_W-1:0]  block_i,
  output word_t               w_o
);
  blk_t  win_q;
  blk_t  blk;
  word_t w_new;

  assign blk   = blk_t'(block_i);
  assign w_new = sml_s1(win_q[BWORDS-2]) + win_q[BWORDS-7] + sml_s0(win_q[1]) + win_q[0];
  assign w_o   = win_q[0];

  for (genvar i = 0; i < BWORDS; i++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      win_q[i] <= '0;
      else if (load_i)  win_q[i] <= blk[i];
      else if (shift_i) win_q[i] <= (i == BWORDS-1) ? w_new : win_q[(i + 1) % BWORDS];
    end
  end
endmodule

// File: rtl/sha256_round.sv
module sha256_round
  import sha256_pkg::*;
(
  input  hstate_t st_i,
  input  word_t   k_i,
  input  word_t   w_i,
  output hstate_t st_o
);
  word_t t1, t2;

  always_comb begin
    t1 = st_i[7] + big_s1(st_i[4]) + ((st_i[4] & st_i[5]) ^ (~st_i[4] & st_i[6])) + k_i + w_i;
    t2 = big_s0(st_i[0]) + ((st_i[0] & st_i[1]) ^ (st_i[0] & st_i[2]) ^ (st_i[1] & st_i[2]));
    st_o    = st_i;
    st_o[0] = t1 + t2;
    st_o[1] = st_i[0];
    st_o[2] = st_i[1];
    st_o[3] = st_i[2];
    st_o[4] = st_i[3] + t1;
    st_o[5] = st_i[4];
    st_o[6] = st_i[5];
    st_o[7] = st_i[6];
  end
endmodule

// File: rtl/sha256_resume_core.sv
module sha256_resume_core
  import sha256_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic                next_i,
  input  logic [BLOCK_W-1:0]  block_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [HWORDS-1:0]   wr_en_i,
  output logic                ready_o,
  output logic [DIGEST_W-1:0] digest_o,
  output logic                digest_valid_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ROUND, ST_FINAL} st_t;

  localparam hstate_t IV_WORDS = hstate_t'(SHA_IV);

  st_t              st_q;
  logic [RND_W-1:0] rnd_q;
  hstate_t          h_q, ws_q, ws_nxt;
  logic             valid_q;
  logic             start;
  word_t            w_cur;

  assign ready_o        = (st_q == ST_IDLE);
  assign start          = ready_o && (init_i || next_i);
  assign digest_o       = h_q;
  assign digest_valid_o = valid_q;

  sha256_sched u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start),
    .shift_i (st_q == ST_ROUND),
    .block_i (block_i),
    .w_o     (w_cur)
  );

  sha256_round u_round (
    .st_i (ws_q),
    .k_i  (SHA_K[rnd_q]),
    .w_i  (w_cur),
    .st_o (ws_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rnd_q   <= '0;
      ws_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q    <= ST_ROUND;
            rnd_q   <= '0;
            ws_q    <= init_i ? IV_WORDS : h_q;
            valid_q <= 1'b0;
          end else if (|wr_en_i) begin
            valid_q <= 1'b0;
          end
        end
        ST_ROUND: begin
          ws_q  <= ws_nxt;
          rnd_q <= rnd_q + 1'b1;
          if (rnd_q == RND_W'(ROUNDS - 1)) st_q <= ST_FINAL;
        end
        ST_FINAL: begin
          st_q    <= ST_IDLE;
          valid_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // chaining words: restart, feed-forward, or restore write
  for (genvar i = 0; i < HWORDS; i++) begin : g_hreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         h_q[i] <= '0;
      else if (start && init_i)            h_q[i] <= IV_WORDS[i];
      else if (st_q == ST_FINAL)           h_q[i] <= h_q[i] + ws_q[i];
      else if (ready_o && !start && wr_en_i[i]) h_q[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/sha256_resume_chk.sv
module sha256_resume_chk
  import sha256_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                init_i,
  input logic                next_i,
  input logic [WORD_W-1:0]   wr_data_i,
  input logic [HWORDS-1:0]   wr_en_i,
  input logic                ready_o,
  input logic [DIGEST_W-1:0] digest_o,
  input logic                digest_valid_o
);
  localparam int BUSY_MAX = ROUNDS + 1;

  logic [7:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= '0;
    else if (ready_o) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= 8'(BUSY_MAX)); // R6

  AST_VALID_IMPLIES_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digest_valid_o |-> ready_o); // R6

  AST_CMD_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (init_i || next_i)) |=> !ready_o); // R6

  AST_BUSY_DIGEST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(digest_o)); // R8

  AST_WRITE_CLEARS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !init_i && !next_i && |wr_en_i) |=> !digest_valid_o); // R7

  AST_WORD0_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !init_i && !next_i && wr_en_i[0]) |=> (digest_o[255:224] == $past(wr_data_i))); // R4

  AST_WORD7_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !init_i && !next_i && wr_en_i[7]) |=> (digest_o[31:0] == $past(wr_data_i))); // R4
endmodule

bind sha256_resume_core sha256_resume_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .init_i         (init_i),
  .next_i         (next_i),
  .wr_data_i      (wr_data_i),
  .wr_en_i        (wr_en_i),
  .ready_o        (ready_o),
  .digest_o       (digest_o),
  .digest_valid_o (digest_valid_o)
);

// File: tb/sha256_resume_core_tb.sv
module sha256_resume_core_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         init_i = 1'b0;
  logic         next_i = 1'b0;
  logic [511:0] block_i = '0;
  logic [31:0]  wr_data_i = '0;
  logic [7:0]   wr_en_i = '0;
  logic         ready_o;
  logic [255:0] digest_o;
  logic         digest_valid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [511:0] BLK_ABC = {32'h61626380, 416'h0, 64'h18};
  localparam logic [511:0] BLK_M1  =
    512'h6162636462636465636465666465666765666768666768696768696A68696A6B696A6B6C6A6B6C6D6B6C6D6E6C6D6E6F6D6E6F706E6F70718000000000000000;
  localparam logic [511:0] BLK_M2  = {480'h0, 32'h1C0};
  localparam logic [255:0] DG_ABC  = 256'hBA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD;
  localparam logic [255:0] DG_M1   = 256'h85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A;
  localparam logic [255:0] DG_M2   = 256'h248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1;

  always #4 clk_i = ~clk_i;

  sha256_resume_core u_dut (
    .clk_i, .rst_ni, .init_i, .next_i, .block_i,
    .wr_data_i, .wr_en_i, .ready_o, .digest_o, .digest_valid_o
  );

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pulse a command at negedge; returns busy length seen at negedges
  task automatic run_cmd(bit ini, bit nxt, logic [511:0] blk, output int busy);
    @(negedge clk_i);
    block_i = blk; init_i = ini; next_i = nxt;
    @(negedge clk_i);
    init_i = 1'b0; next_i = 1'b0;
    busy = 0;
    while (!ready_o && busy < 300) begin
      busy++;
      @(negedge clk_i);
    end
  endtask

  task automatic write_word(int idx, logic [31:0] d);
    @(negedge clk_i);
    wr_data_i = d; wr_en_i = 8'(1 << idx);
    @(negedge clk_i);
    wr_en_i = '0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 ready", 256'(ready_o), 256'd1);
    chk("R1 valid", 256'(digest_valid_o), 256'd0);
    chk("R1 digest", digest_o, 256'd0);
  endtask

  task automatic t_abc;
    int busy;
    run_cmd(1'b1, 1'b0, BLK_ABC, busy);
    chk("R6 busy length", 256'(busy), 256'd65);
    chk("R6 valid with ready", 256'(digest_valid_o), 256'd1);
    chk("R2 abc digest", digest_o, DG_ABC);
  endtask

  task automatic t_two_block;
    int busy;
    run_cmd(1'b1, 1'b0, BLK_M1, busy);
    chk("R3 first block", digest_o, DG_M1);
    run_cmd(1'b0, 1'b1, BLK_M2, busy);
    chk("R3 chained block", digest_o, DG_M2);
  endtask

  task automatic t_restore;
    int busy;
    for (int i = 0; i < 8; i++) write_word(i, DG_M1[255-32*i -: 32]);
    chk("R4 restored order", digest_o, DG_M1);
    chk("R7 valid cleared", 256'(digest_valid_o), 256'd0);
    run_cmd(1'b0, 1'b1, BLK_M2, busy);
    chk("R5 resumed digest", digest_o, DG_M2);
    write_word(3, 32'hDEADBEEF);
    chk("R7 single write clears", 256'(digest_valid_o), 256'd0);
    chk("R4 word3 slot", {digest_o[159:128]}, 256'hDEADBEEF);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk_i);
    block_i = BLK_ABC; init_i = 1'b1;
    @(negedge clk_i);
    init_i = 1'b0;
    repeat (5) @(negedge clk_i);
    block_i = BLK_M1; next_i = 1'b1; init_i = 1'b1;
    wr_en_i = 8'hFF; wr_data_i = 32'h0;
    @(negedge clk_i);
    next_i = 1'b0; init_i = 1'b0; wr_en_i = '0;
    chk("R8 still busy", 256'(ready_o), 256'd0);
    for (int n = 0; n < 300 && !ready_o; n++) @(negedge clk_i);
    chk("R8 result undisturbed", digest_o, DG_ABC);
  endtask

  task automatic t_priority;
    int busy;
    for (int i = 0; i < 8; i++) write_word(i, 32'h1111_1111 * (i + 1));
    @(negedge clk_i);
    block_i = BLK_ABC; init_i = 1'b1; next_i = 1'b1;
    wr_en_i = 8'h01; wr_data_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    init_i = 1'b0; next_i = 1'b0; wr_en_i = '0;
    busy = 1;
    while (!ready_o && busy < 300) begin busy++; @(negedge clk_i); end
    chk("R9 init wins", digest_o, DG_ABC);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_abc();
    t_two_block();
    t_restore();
    t_busy_ignore();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule